// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block applies the exception outcome of one floating-point operation to a floating-point status word. An operation unit presents the status word as it stood before the operation, a 5-bit vector of the IEEE exceptions the operation raised, and the current and next program counters. The block checks whether any raised exception is enabled for trapping. It reduces the vector to one exception when a trap is taken. It then rewrites the current-exception field and, only when no trap is taken, merges the vector into the accrued field. When a trap is taken it sets the trap-type bit for an IEEE exception. When no trap is taken it steps the program counters past the instruction.

The result is registered. The updated status word, the trap flag and the counters appear one clock after the input strobe, with a one-cycle valid pulse. Trap vectoring and the arithmetic itself are handled elsewhere.

Top module: `fp_exc_recorder`

## Requirements
- R1: While reset is asserted, and after it until the first operation, `outValid`, `trapOut`, `statusOut`, `pcOut` and `npcOut` are all zero.
- R2: `trapOut` is 1 exactly when the exception vector and the trap-enable field (status bits 27:23, bit 23+k enabling vector bit k) share a set bit. The vector bits are inexact=0, divide-by-zero=1, underflow=2, overflow=3, invalid=4.
- R3: On a trap, the current-exception field (status bits 4:0) holds exactly one bit: the highest-numbered bit of the vector that is also enabled, so invalid outranks overflow, then underflow, divide-by-zero and inexact. Raised bits that are not enabled are dropped.
- R4: Without a trap, the current-exception field is overwritten with the full vector, even when several bits are set or none.
- R5: Without a trap, the accrued field (status bits 9:5) becomes its old value ORed with the vector. On a trap it keeps its old value.
- R6: On a trap, status bit 14 is set. Without a trap, bit 14 keeps its input value.
- R7: All status bits outside 4:0, 9:5 and 14 pass through unchanged, including the trap-enable field.
- R8: Without a trap, `pcOut` equals `npcIn` and `npcOut` equals `npcIn` + 4, wrapping at the counter width. On a trap, `pcOut` and `npcOut` equal `pcIn` and `npcIn`.
- R9: Results appear on the clock edge after an `inValid` cycle, with `outValid` high for exactly that one cycle. Outputs keep their last values while no new operation arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation outcome present this cycle |
| statusIn | input | STAT_W | Status word before the update |
| excVec | input | 5 | Raised exceptions (4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact) |
| pcIn | input | PC_W | Program counter of the operation |
| npcIn | input | PC_W | Next program counter |
| outValid | output | 1 | Result valid, one cycle after inValid |
| statusOut | output | STAT_W | Updated status word |
| trapOut | output | 1 | Operation traps |
| pcOut | output | PC_W | Updated program counter |
| npcOut | output | PC_W | Updated next program counter |

## Verification
Every result (status word, trap flag, both counters and the valid pulse) is due on the first rising edge after the `inValid` cycle. The bench drives inputs on the falling edge and lowers `inValid` on the next falling edge. It samples all outputs on that falling edge, half a period after the register loads, so no check races the edge. An idle falling edge after each operation checks that `outValid` has dropped and that the status word held its value.

// File: rtl/fp_exc_recorder_pkg.sv
package fp_exc_recorder_pkg;
  localparam int EXC_W        = 5;
  localparam int CUR_LSB      = 0;
  localparam int ACC_LSB      = CUR_LSB + EXC_W;
  localparam int MASK_LSB     = 23;
  localparam int TRAPTYPE_BIT = 14;
  localparam int PC_STEP      = 4;

  typedef struct packed {
    logic             load;
    logic             doTrap;
    logic             doAccrue;
    logic             doAdvance;
    logic [EXC_W-1:0] curExc;
  } strobe_t;
endpackage

// File: rtl/fp_exc_recorder_ctrl.sv
module fp_exc_recorder_ctrl
  import fp_exc_recorder_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [EXC_W-1:0]  excVec,
  output strobe_t           strobes,
  output logic              outValid
);
  logic [EXC_W-1:0] enabledExc;
  logic [EXC_W-1:0] topExc;
  logic             trapNow;

  assign enabledExc = excVec & statusIn[MASK_LSB +: EXC_W];
  assign trapNow    = |enabledExc;

  // Upward scan: the highest enabled bit is written last and wins.
  always_comb begin
    topExc = '0;
    for (int i = 0; i < EXC_W; i++) begin
      if (enabledExc[i]) topExc = EXC_W'(1) << i;
    end
  end

  always_comb begin
    strobes.load      = inValid;
    strobes.doTrap    = trapNow;
    strobes.doAccrue  = !trapNow;
    strobes.doAdvance = !trapNow;
    strobes.curExc    = trapNow ? topExc : excVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fp_exc_recorder_dp.sv
module fp_exc_recorder_dp
  import fp_exc_recorder_pkg::*;
#(
  parameter int STAT_W = 64,
  parameter int PC_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [PC_W-1:0]   npcIn,
  output logic [STAT_W-1:0] statusOut,
  output logic              trapOut,
  output logic [PC_W-1:0]   pcOut,
  output logic [PC_W-1:0]   npcOut
);
  logic [STAT_W-1:0] statusNext;
  logic [PC_W-1:0]   pcNext;
  logic [PC_W-1:0]   npcNext;

  always_comb begin
    statusNext = statusIn;
    statusNext[CUR_LSB +: EXC_W] = strobes.curExc;
    if (strobes.doAccrue)
      statusNext[ACC_LSB +: EXC_W] = statusIn[ACC_LSB +: EXC_W] | strobes.curExc;
    if (strobes.doTrap)
      statusNext[TRAPTYPE_BIT] = 1'b1;
  end

  always_comb begin
    if (strobes.doAdvance) begin
      pcNext  = npcIn;
      npcNext = npcIn + PC_W'(PC_STEP);
    end else begin
      pcNext  = pcIn;
      npcNext = npcIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOut <= '0;
      trapOut   <= 1'b0;
      pcOut     <= '0;
      npcOut    <= '0;
    end else if (strobes.load) begin
      statusOut <= statusNext;
      trapOut   <= strobes.doTrap;
      pcOut     <= pcNext;
      npcOut    <= npcNext;
    end
  end
endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder
  import fp_exc_recorder_pkg::*;
#(
  parameter int STAT_W = 64,
  parameter int PC_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [STAT_W-1:0] statusIn,
  input  logic [EXC_W-1:0]  excVec,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [PC_W-1:0]   npcIn,
  output logic              outValid,
  output logic [STAT_W-1:0] statusOut,
  output logic              trapOut,
  output logic [PC_W-1:0]   pcOut,
  output logic [PC_W-1:0]   npcOut
);
  strobe_t strobes;

  fp_exc_recorder_ctrl #(.STAT_W(STAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .statusIn(statusIn),
    .excVec(excVec), .strobes(strobes), .outValid(outValid)
  );

  fp_exc_recorder_dp #(.STAT_W(STAT_W), .PC_W(PC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .statusIn(statusIn),
    .pcIn(pcIn), .npcIn(npcIn), .statusOut(statusOut), .trapOut(trapOut),
    .pcOut(pcOut), .npcOut(npcOut)
  );
endmodule

// File: rtl/fp_exc_recorder_chk.sv
module fp_exc_recorder_chk
  import fp_exc_recorder_pkg::*;
#(
  parameter int STAT_W = 64,
  parameter int PC_W   = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [STAT_W-1:0] statusIn,
  input logic [EXC_W-1:0]  excVec,
  input logic [PC_W-1:0]   pcIn,
  input logic [PC_W-1:0]   npcIn,
  input logic              outValid,
  input logic [STAT_W-1:0] statusOut,
  input logic              trapOut,
  input logic [PC_W-1:0]   pcOut,
  input logic [PC_W-1:0]   npcOut
);
  a_r2_trap_decision: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> trapOut == |($past(excVec) & $past(statusIn[MASK_LSB +: EXC_W])));

  a_r3_single_cur_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && trapOut) |-> $countones(statusOut[CUR_LSB +: EXC_W]) == 1);

  a_r5_accrued_held_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (!trapOut || statusOut[ACC_LSB +: EXC_W] == $past(statusIn[ACC_LSB +: EXC_W])));

  a_r6_traptype_set: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && trapOut) |-> statusOut[TRAPTYPE_BIT]);

  a_r8_pc_advance: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (trapOut || pcOut == $past(npcIn)));

  a_r8_pc_hold_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (!trapOut || (pcOut == $past(pcIn) && npcOut == $past(npcIn))));

  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && outValid) |=> $stable(statusOut));
endmodule

bind fp_exc_recorder fp_exc_recorder_chk #(.STAT_W(STAT_W), .PC_W(PC_W)) i_chk (.*);

// File: tb/test_fp_exc_recorder.sv
`timescale 1ns/1ps
module test_fp_exc_recorder;
  localparam int STAT_W = 64;
  localparam int PC_W   = 64;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [STAT_W-1:0] statusIn;
  logic [4:0]        excVec;
  logic [PC_W-1:0]   pcIn, npcIn;
  logic              outValid, trapOut;
  logic [STAT_W-1:0] statusOut;
  logic [PC_W-1:0]   pcOut, npcOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_exc_recorder #(.STAT_W(STAT_W), .PC_W(PC_W)) i_fp_exc_recorder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .statusIn(statusIn),
    .excVec(excVec), .pcIn(pcIn), .npcIn(npcIn), .outValid(outValid),
    .statusOut(statusOut), .trapOut(trapOut), .pcOut(pcOut), .npcOut(npcOut)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic expTrap(input logic [STAT_W-1:0] st, input logic [4:0] ev);
    return |(ev & st[27:23]);
  endfunction

  function automatic logic [4:0] expCur(input logic [STAT_W-1:0] st, input logic [4:0] ev);
    logic [4:0] en = ev & st[27:23];
    if (en == 5'd0) return ev;
    if (en[4]) return 5'b10000;
    if (en[3]) return 5'b01000;
    if (en[2]) return 5'b00100;
    if (en[1]) return 5'b00010;
    return 5'b00001;
  endfunction

  task automatic runOp(input logic [STAT_W-1:0] st, input logic [4:0] ev,
                       input logic [PC_W-1:0] pc, input logic [PC_W-1:0] npc);
    logic             t;
    logic [4:0]       c;
    logic [STAT_W-1:0] keepMask;
    logic [STAT_W-1:0] held;
    t = expTrap(st, ev);
    c = expCur(st, ev);
    keepMask = ~((64'h1f) | (64'h1f << 5) | (64'h1 << 14));
    @(negedge clk);
    statusIn = st; excVec = ev; pcIn = pc; npcIn = npc; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 outValid", 64'(outValid), 64'd1);
    check("R2 trap", 64'(trapOut), 64'(t));
    check(t ? "R3 cur field" : "R4 cur field", 64'(statusOut[4:0]), 64'(c));
    check("R5 accrued", 64'(statusOut[9:5]), t ? 64'(st[9:5]) : 64'(st[9:5] | ev));
    check("R6 bit14", 64'(statusOut[14]), t ? 64'd1 : 64'(st[14]));
    check("R7 passthrough", statusOut & keepMask, st & keepMask);
    check("R8 pc", pcOut, t ? pc : npc);
    check("R8 npc", npcOut, t ? npc : npc + 64'd4);
    held = statusOut;
    statusIn = ~st; excVec = ~ev;
    @(negedge clk);
    check("R9 valid drop", 64'(outValid), 64'd0);
    check("R9 hold", statusOut, held);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [STAT_W-1:0] st;
    int unused;
    unused = $urandom(32'h5eed1234);
    rstN = 1'b0; inValid = 1'b0; statusIn = '0; excVec = '0; pcIn = '0; npcIn = '0;
    repeat (3) @(negedge clk);
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 trap", 64'(trapOut), 64'd0);
    check("R1 status", statusOut, 64'd0);
    check("R1 pc", pcOut, 64'd0);
    check("R1 npc", npcOut, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 64'(outValid), 64'd0);

    // R4: no exceptions, status cleared current field
    runOp(64'h0000_0000_0000_001f, 5'b00000, 64'h100, 64'h104);
    // R4/R5: several raised, none enabled
    runOp(64'hffff_ffff_f07f_bfe0 & ~(64'h1f << 23), 5'b10101, 64'h200, 64'h204);
    // R3: all enabled, all raised -> invalid
    runOp(64'h0000_0000_0f80_0000, 5'b11111, 64'h300, 64'h304);
    // R3: overflow beats inexact
    runOp(64'h0000_0000_0480_03e0, 5'b01001, 64'h400, 64'h404);
    // R3: only inexact enabled, many raised -> inexact only
    runOp(64'h0000_0000_0080_0000, 5'b11111, 64'h500, 64'h504);
    // R3: underflow beats divide-by-zero
    runOp(64'h0000_0000_0300_0000, 5'b00110, 64'h600, 64'h604);
    // R8: counter wrap without trap
    runOp(64'h0, 5'b00001, 64'hffff_ffff_ffff_fff8, 64'hffff_ffff_ffff_fffc);
    // R6: trap with bit 14 already set
    runOp(64'h0000_0000_0100_4000, 5'b00010, 64'h700, 64'h704);

    for (int i = 0; i < 300; i++) begin
      st = {$urandom(), $urandom()};
      runOp(st, 5'($urandom()), {$urandom(), $urandom()}, {$urandom(), $urandom()});
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule